// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Controller

This block chooses which of two programmed charge-pump current codes drives the loop at any moment. A base code is used while the synthesizer is settled. A boost code is used while it is being retuned, so that the loop pulls in faster. The boost is requested through a gain bit. A write port from the counter register sets or clears that bit. The block drives the chosen 3-bit code and the live state of the gain bit.

Two modes exist once the fastlock enable is set. In the manual mode the gain bit stays set until software writes it back to zero. In the timed mode, setting the gain bit loads a timeout counter. The counter steps once per phase-detector cycle, and when it expires the hardware clears the gain bit itself, so the current falls back without a second write. A power-down input holds the counter at its idle load state and abandons any timeout in progress.

Top module: `cp_boost_top`

## Requirements
- R1: After reset the gain state is 0 and the current code equals the base code.
- R2: While the fastlock enable is 0, the current code equals the base code whatever the gain state is.
- R3: While the fastlock enable is 1, the current code equals the boost code when the gain state is 1 and the base code when it is 0.
- R4: A gain write strobe sets the gain state to the written value at the clock edge where the strobe is sampled.
- R5: In manual mode (mode bit 0), a set gain state stays 1 for any number of phase-detector ticks and clears only on a write of 0.
- R6: In timed mode (enable 1, mode bit 1), a write of 1 loads a timeout of 4×code+3 ticks, where code is the 4-bit unsigned timeout field (0 gives 3 ticks, 15 gives 63 ticks). The gain state clears at the edge that samples the last of those ticks.
- R7: Only clock edges that sample the tick input high advance the timeout. Without ticks, the gain state holds.
- R8: A new write of 1 during a running timeout restarts the full count.
- R9: A write of 0 during a running timeout clears the gain state at once. The gain state stays 0 under further ticks.
- R10: Power-down stops the timeout and keeps the gain state. On release with the gain state still 1 in timed mode, the first edge reloads the counter and a full timeout follows.
- R11: The timer runs only when enable and mode bit are both 1. If the gain state is 1 and timed mode is then selected, the first edge loads the counter and a full timeout follows.
- R12: A write strobe sampled at the same edge as the final tick takes priority over expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| boostEn | input | 1 | Fastlock enable from the function register |
| boostMode | input | 1 | 0 = manual mode, 1 = timed mode |
| holdCode | input | 4 | Timeout code; timeout is 4×code+3 ticks |
| curBase | input | 3 | Steady-state current code |
| curBoost | input | 3 | Fastlock current code |
| gainWrStb | input | 1 | One-cycle strobe for a write of the gain bit |
| gainWrVal | input | 1 | Value carried by the gain write |
| pdTick | input | 1 | One phase-detector cycle elapsed |
| powerDown | input | 1 | Power-down request |
| curCode | output | 3 | Active current code |
| gainState | output | 1 | Live gain bit |

## Verification
The hardest case to reach from the ports is a write that lands on the very edge where the final tick would expire the timeout. A second hard case is a timeout that resumes after power-down or after a mode switch while the gain bit is held. The bench counts ticks exactly, holding the tick input high on every cycle from a known edge. This puts the colliding write on the computed expiry edge. The bench then measures the edges until the gain bit falls, which shows whether the load edge is counted or consumed.

// File: rtl/cp_boost_pkg.sv
package cp_boost_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } tmrStb_t;
endpackage

// File: rtl/cp_boost_ctl.sv
module cp_boost_ctl
  import cp_boost_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    boostEn,
  input  logic    boostMode,
  input  logic    gainWrStb,
  input  logic    gainWrVal,
  input  logic    pdTick,
  input  logic    powerDown,
  input  logic    lastTick,
  output tmrStb_t stb,
  output logic    gainQ,
  output logic    boostSel
);
  logic runQ, armed, setWr, clrWr, expire;

  always_comb begin
    armed  = boostEn & boostMode & ~powerDown;
    setWr  = gainWrStb & gainWrVal;
    clrWr  = gainWrStb & ~gainWrVal;
    expire = armed & runQ & pdTick & lastTick & ~gainWrStb;
    stb.load  = armed & (setWr | (gainQ & ~runQ & ~gainWrStb));
    stb.dec   = armed & runQ & pdTick & ~gainWrStb & ~lastTick;
    stb.clear = runQ & ~stb.load & (~armed | clrWr | expire);
    boostSel  = boostEn & gainQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainQ <= 1'b0;
      runQ  <= 1'b0;
    end else begin
      if (gainWrStb)   gainQ <= gainWrVal;
      else if (expire) gainQ <= 1'b0;
      if (stb.load)       runQ <= 1'b1;
      else if (stb.clear) runQ <= 1'b0;
    end
  end

  // R10
  pd_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !runQ);
  // R4
  set_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gainWrStb && gainWrVal) |=> gainQ);
  // R5
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gainQ && !gainWrStb && !boostMode) |=> gainQ);
  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.dec, stb.clear}));
endmodule

// File: rtl/cp_boost_dp.sv
module cp_boost_dp
  import cp_boost_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CUR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStb_t           stb,
  input  logic [CODE_W-1:0] holdCode,
  input  logic              boostSel,
  input  logic [CUR_W-1:0]  curBase,
  input  logic [CUR_W-1:0]  curBoost,
  output logic              lastTick,
  output logic [CUR_W-1:0]  curCode
);
  localparam int MAX_LEN = 4 * ((1 << CODE_W) - 1) + 3;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt, loadVal;

  assign loadVal  = CNT_W'({holdCode, 2'b11});
  assign lastTick = (cnt == CNT_W'(1));
  assign curCode  = boostSel ? curBoost : curBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (stb.load)  cnt <= loadVal;
    else if (stb.dec)   cnt <= cnt - CNT_W'(1);
    else if (stb.clear) cnt <= '0;
  end

  // R6
  load_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (cnt == CNT_W'(4 * $past(holdCode) + 3)));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.dec |-> (cnt > CNT_W'(1)));
  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.dec && !stb.clear) |=> $stable(cnt));
endmodule

// File: rtl/cp_boost_top.sv
module cp_boost_top
  import cp_boost_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CUR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              boostEn,
  input  logic              boostMode,
  input  logic [CODE_W-1:0] holdCode,
  input  logic [CUR_W-1:0]  curBase,
  input  logic [CUR_W-1:0]  curBoost,
  input  logic              gainWrStb,
  input  logic              gainWrVal,
  input  logic              pdTick,
  input  logic              powerDown,
  output logic [CUR_W-1:0]  curCode,
  output logic              gainState
);
  tmrStb_t stb;
  logic    lastTick, boostSel;

  cp_boost_ctl u_ctl (
    .clk(clk), .rstN(rstN), .boostEn(boostEn), .boostMode(boostMode),
    .gainWrStb(gainWrStb), .gainWrVal(gainWrVal), .pdTick(pdTick),
    .powerDown(powerDown), .lastTick(lastTick), .stb(stb),
    .gainQ(gainState), .boostSel(boostSel)
  );

  cp_boost_dp #(.CODE_W(CODE_W), .CUR_W(CUR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .holdCode(holdCode),
    .boostSel(boostSel), .curBase(curBase), .curBoost(curBoost),
    .lastTick(lastTick), .curCode(curCode)
  );

  // R9
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gainState) |-> ($past(gainWrStb) || ($past(boostEn) && $past(boostMode))));
endmodule

// File: tb/sim_cp_boost_top.sv
module sim_cp_boost_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic boostEn = 0, boostMode = 0, gainWrStb = 0, gainWrVal = 0, pdTick = 0, powerDown = 0;
  logic [3:0] holdCode = 0;
  logic [2:0] curBase = 3'b010, curBoost = 3'b101;
  logic [2:0] curCode;
  logic gainState;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cp_boost_top u0 (.*);

  // row: {en, mode, code[3:0], expected edges[6:0]} ; 0 = never clears
  localparam logic [12:0] VEC [7] = '{
    {1'b1, 1'b1, 4'd0,  7'd3},
    {1'b1, 1'b1, 4'd1,  7'd7},
    {1'b1, 1'b1, 4'd5,  7'd23},
    {1'b1, 1'b1, 4'd15, 7'd63},
    {1'b1, 1'b0, 4'd2,  7'd0},
    {1'b0, 1'b1, 4'd3,  7'd0},
    {1'b0, 1'b0, 4'd0,  7'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic v);
    @(negedge clk); gainWrStb = 1; gainWrVal = v;
    @(posedge clk); @(negedge clk); gainWrStb = 0;
  endtask

  task automatic waitFall(input int maxE, output int edges);
    edges = 0;
    while (gainState && edges < maxE) begin
      @(posedge clk); @(negedge clk); edges++;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finishRun();
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 gain", gainState, 0);
    chk("R1 code", curCode, curBase);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      boostEn = VEC[i][12]; boostMode = VEC[i][11]; holdCode = VEC[i][10:7];
      pdTick = 0;
      wr(1'b1);
      chk("R4 set", gainState, 1);
      if (VEC[i][12]) chk("R3 boost code", curCode, curBoost);
      else            chk("R2 base code", curCode, curBase);
      pdTick = 1;
      waitFall(70, e);
      if (VEC[i][6:0] != 0) begin
        chk("R6 timeout edges", e, VEC[i][6:0]);
        chk("R3 base after timeout", curCode, curBase);
      end else begin
        chk("R5 no auto clear", gainState, 1);
        pdTick = 0;
        wr(1'b0);
        chk("R4 clear", gainState, 0);
      end
      pdTick = 0;
    end

    // R7 no ticks, no progress
    boostEn = 1; boostMode = 1; holdCode = 0;
    wr(1'b1);
    repeat (20) @(negedge clk);
    chk("R7 hold without tick", gainState, 1);
    pdTick = 1; waitFall(70, e); pdTick = 0;
    chk("R7 ticks after idle", e, 3);

    // R8 restart
    holdCode = 1;
    wr(1'b1);
    pdTick = 1; repeat (4) @(negedge clk);
    gainWrStb = 1; gainWrVal = 1; @(negedge clk); gainWrStb = 0;
    waitFall(70, e); pdTick = 0;
    chk("R8 restart", e, 7);

    // R9 clear mid count
    wr(1'b1);
    pdTick = 1; repeat (2) @(negedge clk);
    gainWrStb = 1; gainWrVal = 0; @(negedge clk); gainWrStb = 0;
    chk("R9 cleared", gainState, 0);
    repeat (10) @(negedge clk);
    chk("R9 stays clear", gainState, 0);
    chk("R9 base code", curCode, curBase);
    pdTick = 0;

    // R10 power-down
    wr(1'b1);
    pdTick = 1; repeat (3) @(negedge clk);
    powerDown = 1; repeat (10) @(negedge clk);
    chk("R10 gain kept", gainState, 1);
    powerDown = 0;
    waitFall(70, e); pdTick = 0;
    chk("R10 full reload", e, 8);

    // R11 mode switch while set
    boostMode = 0;
    wr(1'b1);
    pdTick = 1; repeat (10) @(negedge clk);
    chk("R11 manual holds", gainState, 1);
    boostMode = 1;
    waitFall(70, e); pdTick = 0;
    chk("R11 start on switch", e, 8);

    // R12 write on expiry edge wins
    holdCode = 0;
    wr(1'b1);
    pdTick = 1; repeat (2) @(negedge clk);
    gainWrStb = 1; gainWrVal = 1; @(negedge clk); gainWrStb = 0;
    chk("R12 write beats expiry", gainState, 1);
    waitFall(70, e); pdTick = 0;
    chk("R12 fresh count", e, 3);

    // R2 enable off while gain set
    boostMode = 0;
    wr(1'b1);
    boostEn = 0; @(negedge clk);
    chk("R2 disabled uses base", curCode, curBase);
    boostEn = 1; @(negedge clk);
    chk("R3 re-enabled uses boost", curCode, curBoost);

    finishRun();
  end
endmodule